// File: doc/BRIEF.md
# Paired Byte FIFOs with Threshold and Idle-Data Interrupts

This block sits between the register side of a serial controller and its serial engine. It holds two byte queues. The transmit queue is filled by register-side writes and drained by the engine. The receive queue is filled by the engine and drained by register-side reads. Each queue can be enabled on its own. Disabling a queue empties it.

Interrupt causes are collected into one sticky status vector of seven bits. The causes are:

- a transmit level at or below its trigger;
- a receive level at or above its trigger;
- a write into a full queue;
- a read from an empty queue;
- receive data that has sat below its trigger, with no receive traffic, for a programmable number of cycles.

Software clears status bits by writing ones. The interrupt line is the OR of the status bits that the enable mask lets through. A packed status word reports both fill levels with their full and empty flags, for polling.

Top module: `xfer_fifo_pair`

## Requirements
- R1: `fifo_sts` carries the TX level in bits 6:0, TX full in bit 7 and TX empty in bit 8. It carries the RX level in bits 22:16, RX full in bit 23 and RX empty in bit 24. All other bits are zero. A level never exceeds DEPTH, and full and empty are never set together.
- R2: Each queue returns bytes in the order they were accepted. `eng_tx_data` and `host_rdata` show the oldest byte during the cycle of the pop strobe, and read as zero when the queue is empty.
- R3: `tx_en` and `rx_en` enable the queues. While an enable is low, its queue is emptied at the next clock edge. Push and pop strobes to it are ignored and raise no error bit.
- R4: A push to a full, enabled queue is dropped, even when a pop happens in the same cycle. A dropped host write sets status bit 3 (TX overrun). A dropped engine push sets status bit 5 (RX overrun).
- R5: A pop from an empty, enabled queue reads zero. An engine pop sets status bit 2 (TX underrun). A host read sets status bit 4 (RX underrun).
- R6: Status bit 0 (TX almost empty) is set at the edge that ends any cycle in which TX is enabled and its level is less than or equal to `tx_trig`.
- R7: Status bit 1 (RX almost full) is set at the edge that ends any cycle in which RX is enabled and its level is nonzero and greater than or equal to `rx_trig`.
- R8: Status bit 6 (trailing) is set at the edge that ends the (N+1)th consecutive cycle meeting all of the following, where N is `trail_cnt`: RX is enabled, the RX level is between 1 and `rx_trig`-1, and neither `eng_rx_push` nor `host_rd` is asserted. Any cycle that breaks the run restarts the count.
- R9: Status bits are sticky. When `irq_clr_we` is high, each bit set in `irq_clr_vec` clears the matching status bit at the next edge. A cause in that same cycle wins over the clear. Bits written as zero are left unchanged.
- R10: `irq_o` is high exactly when some bit of `irq_stat & irq_en` is set. It follows `irq_stat` with no added delay.
- R11: After the synchronous active-low reset, both queues are empty and `irq_stat` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive queue enable |
| tx_en | input | 1 | Transmit queue enable |
| rx_trig | input | 7 | Receive almost-full trigger level |
| tx_trig | input | 7 | Transmit almost-empty trigger level |
| trail_cnt | input | 4 | Idle cycles allowed before the trailing cause |
| irq_en | input | 7 | Interrupt enable mask, one bit per status bit |
| host_wr | input | 1 | Register-side push into the transmit queue |
| host_wdata | input | DW | Byte to push into the transmit queue |
| host_rd | input | 1 | Register-side pop from the receive queue |
| host_rdata | output | DW | Oldest receive byte, zero when empty |
| eng_tx_pop | input | 1 | Engine pop from the transmit queue |
| eng_tx_data | output | DW | Oldest transmit byte, zero when empty |
| eng_rx_push | input | 1 | Engine push into the receive queue |
| eng_rx_data | input | DW | Byte to push into the receive queue |
| irq_clr_we | input | 1 | Write strobe for the clear vector |
| irq_clr_vec | input | 7 | Ones clear the matching status bits |
| fifo_sts | output | 32 | Packed levels and full/empty flags |
| irq_stat | output | 7 | Sticky interrupt status |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with DEPTH of 16 and an 8-bit data width. The small depth lets random traffic reach full, overrun, empty and underrun many times within a short run. It also lets every trigger value from 0 up to and past the depth be tried. Trailing counts from 0 to 15 are swept while receive data idles, so the bench sees the cause fire at the exact cycle and sees it restarted by traffic.

// File: rtl/xfer_fifo_pkg.sv
// Package: shared constants for the paired byte FIFO block.
// Assumes: status-bit indices are fixed because software decodes them.
package xfer_fifo_pkg;
    localparam int IRQ_W      = 7;
    localparam int IRQ_TX_AE  = 0;
    localparam int IRQ_RX_AF  = 1;
    localparam int IRQ_TX_UDR = 2;
    localparam int IRQ_TX_OVR = 3;
    localparam int IRQ_RX_UDR = 4;
    localparam int IRQ_RX_OVR = 5;
    localparam int IRQ_TRAIL  = 6;
    localparam int LVL_W      = 7;
    typedef logic [IRQ_W-1:0] irq_vec_t;
endpackage

// File: rtl/xfer_byte_fifo.sv
// Module: one synchronous byte queue with drop-on-full and zero-on-empty.
// Assumes: DEPTH is a power of two so the pointers wrap naturally.
// Full and empty decisions use the state before the edge.
module xfer_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          ovf_evt,
    output logic          udf_evt
);
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [LW-1:0] count;
    logic [DW-1:0] mem [DEPTH];
    logic          do_push;
    logic          do_pop;

    // Purpose: decode accepted operations and error events.
    always_comb begin
        full    = (count == LW'(DEPTH));
        empty   = (count == '0);
        do_push = en && push && !full;
        do_pop  = en && pop && !empty;
        ovf_evt = en && push && full;
        udf_evt = en && pop && empty;
    end

    // Purpose: advance the pointers and the count; a disabled queue is flushed.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Purpose: store accepted bytes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Purpose: present the oldest byte, or zero when nothing is held.
    always_comb begin
        head_data = empty ? '0 : mem[rd_ptr];
        level     = count;
    end
endmodule

// File: rtl/xfer_trail_timer.sv
// Module: counts consecutive idle cycles of below-trigger receive data.
// Assumes: 'armed' and 'activity' are evaluated on the pre-edge state.
module xfer_trail_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          armed,
    input  logic          activity,
    input  logic [CW-1:0] limit,
    output logic          fire
);
    logic [CW-1:0] idle_cnt;

    // Purpose: the cause fires when the idle run has lasted 'limit' cycles.
    always_comb fire = armed && !activity && (idle_cnt == limit);

    // Purpose: restart on traffic or disarm, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || activity) idle_cnt <= '0;
        else if (idle_cnt != limit)       idle_cnt <= idle_cnt + 1'b1;
    end
endmodule

// File: rtl/xfer_irq_status.sv
// Module: sticky cause register with write-one-to-clear and masked output.
// Assumes: a cause and a clear of the same bit in one cycle keep the bit set.
module xfer_irq_status #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_vec,
    input  logic [W-1:0] en_vec,
    output logic [W-1:0] stat,
    output logic         irq
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic q;
        // Purpose: hold one cause bit; a cause outranks a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                    q <= 1'b0;
            else if (set_vec[b])           q <= 1'b1;
            else if (clr_we && clr_vec[b]) q <= 1'b0;
        end
        assign stat[b] = q;
    end

    // Purpose: raise the request for any enabled pending cause.
    always_comb irq = |(stat & en_vec);
endmodule

// File: rtl/xfer_fifo_pair.sv
// Module: transmit and receive byte queues with a merged interrupt status.
// Assumes: the register side and the serial engine share clk; all strobes
// are single-cycle and sampled at the rising edge.
module xfer_fifo_pair
    import xfer_fifo_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int DW      = 8,
    parameter int TRAIL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               tx_en,
    input  logic [LVL_W-1:0]   rx_trig,
    input  logic [LVL_W-1:0]   tx_trig,
    input  logic [TRAIL_W-1:0] trail_cnt,
    input  logic [IRQ_W-1:0]   irq_en,
    input  logic               host_wr,
    input  logic [DW-1:0]      host_wdata,
    input  logic               host_rd,
    output logic [DW-1:0]      host_rdata,
    input  logic               eng_tx_pop,
    output logic [DW-1:0]      eng_tx_data,
    input  logic               eng_rx_push,
    input  logic [DW-1:0]      eng_rx_data,
    input  logic               irq_clr_we,
    input  logic [IRQ_W-1:0]   irq_clr_vec,
    output logic [31:0]        fifo_sts,
    output logic [IRQ_W-1:0]   irq_stat,
    output logic               irq_o
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0]    tx_lvl, rx_lvl;
    logic [LVL_W-1:0] tx_lvl_x, rx_lvl_x;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_ovf, tx_udf, rx_ovf, rx_udf;
    logic             trail_armed, trail_fire;
    irq_vec_t         cause;

    xfer_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .en(tx_en),
        .push(host_wr), .push_data(host_wdata), .pop(eng_tx_pop),
        .head_data(eng_tx_data), .level(tx_lvl), .full(tx_full),
        .empty(tx_empty), .ovf_evt(tx_ovf), .udf_evt(tx_udf)
    );

    xfer_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .en(rx_en),
        .push(eng_rx_push), .push_data(eng_rx_data), .pop(host_rd),
        .head_data(host_rdata), .level(rx_lvl), .full(rx_full),
        .empty(rx_empty), .ovf_evt(rx_ovf), .udf_evt(rx_udf)
    );

    // Purpose: widen the levels to the status field width.
    always_comb begin
        tx_lvl_x = LVL_W'(tx_lvl);
        rx_lvl_x = LVL_W'(rx_lvl);
    end

    // Purpose: arm the idle timer while held receive data is below its trigger.
    always_comb trail_armed = rx_en && !rx_empty && (rx_lvl_x < rx_trig);

    xfer_trail_timer #(.CW(TRAIL_W)) u_trail (
        .clk(clk), .rst_n(rst_n), .armed(trail_armed),
        .activity(eng_rx_push || host_rd), .limit(trail_cnt),
        .fire(trail_fire)
    );

    // Purpose: gather every interrupt cause into one vector.
    always_comb begin
        cause             = '0;
        cause[IRQ_TX_AE]  = tx_en && (tx_lvl_x <= tx_trig);
        cause[IRQ_RX_AF]  = rx_en && !rx_empty && (rx_lvl_x >= rx_trig);
        cause[IRQ_TX_UDR] = tx_udf;
        cause[IRQ_TX_OVR] = tx_ovf;
        cause[IRQ_RX_UDR] = rx_udf;
        cause[IRQ_RX_OVR] = rx_ovf;
        cause[IRQ_TRAIL]  = trail_fire;
    end

    xfer_irq_status #(.W(IRQ_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(cause), .clr_we(irq_clr_we),
        .clr_vec(irq_clr_vec), .en_vec(irq_en), .stat(irq_stat), .irq(irq_o)
    );

    // Purpose: pack levels and flags into the polled status word.
    always_comb fifo_sts = {7'b0, rx_empty, rx_full, rx_lvl_x,
                            7'b0, tx_empty, tx_full, tx_lvl_x};
endmodule

// File: rtl/xfer_fifo_pair_chk.sv
// Module: temporal checks on the ports of xfer_fifo_pair, bound below.
// Assumes: the same clock and synchronous reset as the checked block.
module xfer_fifo_pair_chk #(
    parameter int DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_en,
    input logic        tx_en,
    input logic [6:0]  tx_trig,
    input logic        host_wr,
    input logic        host_rd,
    input logic [7:0]  host_rdata,
    input logic        irq_clr_we,
    input logic [6:0]  irq_en,
    input logic [31:0] fifo_sts,
    input logic [6:0]  irq_stat,
    input logic        irq_o
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_sts[7] && fifo_sts[8]) && !(fifo_sts[23] && fifo_sts[24])); // R1
    AST_LEVEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_sts[6:0] <= 7'(DEPTH)) && (fifo_sts[22:16] <= 7'(DEPTH))); // R1
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_sts[24] |-> (host_rdata == 8'h00)); // R2
    AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> fifo_sts[8]); // R3
    AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && host_wr && fifo_sts[7]) |=> irq_stat[3]); // R4
    AST_RX_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && host_rd && fifo_sts[24]) |=> irq_stat[4]); // R5
    AST_TX_ALMOST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && (fifo_sts[6:0] <= tx_trig)) |=> irq_stat[0]); // R6
    AST_STICKY_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_clr_we |=> ((irq_stat & $past(irq_stat)) == $past(irq_stat))); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_stat & irq_en) == 7'h00) |-> !irq_o); // R10
endmodule

bind xfer_fifo_pair xfer_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
    .tx_trig(tx_trig), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .irq_clr_we(irq_clr_we), .irq_en(irq_en),
    .fifo_sts(fifo_sts), .irq_stat(irq_stat), .irq_o(irq_o)
);

// File: tb/xfer_fifo_pair_bench.sv
// Bench: behavioural queue model compared with the block on every clock.
module xfer_fifo_pair_bench;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, tx_en = 1'b0;
    logic [6:0]  rx_trig = '0, tx_trig = '0;
    logic [3:0]  trail_cnt = '0;
    logic [6:0]  irq_en = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [7:0]  host_wdata = '0, eng_rx_data = '0;
    logic        irq_clr_we = 1'b0;
    logic [6:0]  irq_clr_vec = '0;
    logic [7:0]  host_rdata, eng_tx_data;
    logic [31:0] fifo_sts;
    logic [6:0]  irq_stat;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [6:0] m_stat = '0;
    int         m_tcnt = 0;

    always #4 clk = ~clk;

    xfer_fifo_pair #(.DEPTH(DEPTH)) u_xfer_fifo_pair (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
        .rx_trig(rx_trig), .tx_trig(tx_trig), .trail_cnt(trail_cnt),
        .irq_en(irq_en), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .eng_tx_pop(eng_tx_pop),
        .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .irq_clr_we(irq_clr_we),
        .irq_clr_vec(irq_clr_vec), .fifo_sts(fifo_sts),
        .irq_stat(irq_stat), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_sts();
        int ts = txq.size();
        int rs = rxq.size();
        return {7'b0, rs == 0, rs == DEPTH, 7'(rs), 7'b0, ts == 0, ts == DEPTH, 7'(ts)};
    endfunction

    // Compare all outputs with the model, then advance the model by one edge.
    task automatic run_cycle();
        logic [6:0] set;
        logic [6:0] clr;
        int ts, rs;
        bit armed, act;
        #1;
        ts = txq.size();
        rs = rxq.size();
        chk("R2 tx head", 32'(eng_tx_data), 32'(ts != 0 ? txq[0] : 8'h00));
        chk("R2 rx head", 32'(host_rdata), 32'(rs != 0 ? rxq[0] : 8'h00));
        chk("R1 status word", fifo_sts, exp_sts());
        chk("R6 tx almost empty", 32'(irq_stat[0]), 32'(m_stat[0]));
        chk("R7 rx almost full", 32'(irq_stat[1]), 32'(m_stat[1]));
        chk("R5 tx underrun", 32'(irq_stat[2]), 32'(m_stat[2]));
        chk("R4 tx overrun", 32'(irq_stat[3]), 32'(m_stat[3]));
        chk("R5 rx underrun", 32'(irq_stat[4]), 32'(m_stat[4]));
        chk("R4 rx overrun", 32'(irq_stat[5]), 32'(m_stat[5]));
        chk("R8 trailing", 32'(irq_stat[6]), 32'(m_stat[6]));
        chk("R10 irq line", 32'(irq_o), 32'((m_stat & irq_en) != 0));
        set = '0;
        set[0] = tx_en && (ts <= int'(tx_trig));
        set[1] = rx_en && rs != 0 && (rs >= int'(rx_trig));
        set[2] = tx_en && eng_tx_pop && ts == 0;
        set[3] = tx_en && host_wr && ts == DEPTH;
        set[4] = rx_en && host_rd && rs == 0;
        set[5] = rx_en && eng_rx_push && rs == DEPTH;
        armed  = rx_en && rs != 0 && (rs < int'(rx_trig));
        act    = eng_rx_push || host_rd;
        set[6] = armed && !act && (m_tcnt == int'(trail_cnt));
        if (!armed || act) m_tcnt = 0;
        else if (m_tcnt != int'(trail_cnt)) m_tcnt = (m_tcnt + 1) % 16;
        if (!tx_en) txq.delete();
        else begin
            if (eng_tx_pop && ts > 0) void'(txq.pop_front());
            if (host_wr && ts < DEPTH) txq.push_back(host_wdata);
        end
        if (!rx_en) rxq.delete();
        else begin
            if (host_rd && rs > 0) void'(rxq.pop_front());
            if (eng_rx_push && rs < DEPTH) rxq.push_back(eng_rx_data);
        end
        clr = irq_clr_we ? irq_clr_vec : 7'h00;
        m_stat = (m_stat & ~clr) | set;
        @(negedge clk);
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; eng_tx_pop = 0; eng_rx_push = 0; irq_clr_we = 0;
    endtask

    task automatic clear_all();
        idle(); irq_clr_we = 1; irq_clr_vec = 7'h7F; run_cycle(); idle();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: both queues empty and no pending causes after reset.
        chk("R11 reset status word", fifo_sts, 32'h0100_0100);
        chk("R11 reset irq status", 32'(irq_stat), 32'h0);
        run_cycle();

        // Fill TX past full (R4), then drain past empty (R5, R6).
        tx_en = 1; rx_en = 1; tx_trig = 4; rx_trig = 8; trail_cnt = 3; irq_en = 7'h7F;
        for (int i = 0; i < DEPTH + 2; i++) begin
            idle(); host_wr = 1; host_wdata = 8'(8'hA0 + i); run_cycle();
        end
        idle(); run_cycle();
        chk("R4 tx overrun flagged", 32'(irq_stat[3]), 32'h1);
        chk("R4 tx keeps first byte", 32'(eng_tx_data), 32'hA0);
        for (int i = 0; i < DEPTH + 2; i++) begin
            idle(); eng_tx_pop = 1; run_cycle();
        end
        idle(); run_cycle();
        chk("R5 tx underrun flagged", 32'(irq_stat[2]), 32'h1);

        // R9: clear everything, then a still-active cause wins over the clear.
        clear_all();
        chk("R9 cleared except live tx threshold", 32'(irq_stat), 32'h01);

        // R8: sweep trailing counts with two bytes idling below trigger 8.
        for (int n = 0; n < 16; n += 5) begin
            trail_cnt = 4'(n);
            idle(); eng_rx_push = 1; eng_rx_data = 8'(n); run_cycle();
            idle(); eng_rx_push = 1; eng_rx_data = 8'(n + 1); run_cycle();
            clear_all();
            repeat (n + 2) begin idle(); run_cycle(); end
            chk("R8 trailing after idle run", 32'(irq_stat[6]), 32'h1);
            idle(); host_rd = 1; run_cycle();
            idle(); host_rd = 1; run_cycle();
        end

        // R7 and R4 on the receive side: fill past full, R5 on empty read.
        for (int i = 0; i < DEPTH + 1; i++) begin
            idle(); eng_rx_push = 1; eng_rx_data = 8'(8'h30 + i); run_cycle();
        end
        idle(); run_cycle();
        chk("R7 rx almost full", 32'(irq_stat[1]), 32'h1);
        chk("R4 rx overrun", 32'(irq_stat[5]), 32'h1);

        // R3: disabling flushes and blocks strobes without errors.
        clear_all();
        rx_en = 0; idle(); run_cycle();
        idle(); host_rd = 1; eng_rx_push = 1; run_cycle();
        idle(); host_rd = 1; run_cycle();
        chk("R3 rx flushed", 32'(fifo_sts[24]), 32'h1);
        chk("R3 no rx errors when disabled", 32'(irq_stat[5:4]), 32'h0);
        rx_en = 1;

        // Random traffic with configuration changes; R10 mask varied.
        for (int blk = 0; blk < 25; blk++) begin
            tx_en = ($urandom_range(0, 7) != 0);
            rx_en = ($urandom_range(0, 7) != 0);
            tx_trig = 7'($urandom_range(0, DEPTH + 2));
            rx_trig = 7'($urandom_range(0, DEPTH + 2));
            trail_cnt = 4'($urandom_range(0, 15));
            irq_en = 7'($urandom);
            for (int c = 0; c < 160; c++) begin
                host_wr = ($urandom_range(0, 99) < 45);
                eng_tx_pop = ($urandom_range(0, 99) < 40);
                eng_rx_push = ($urandom_range(0, 99) < 25 + blk);
                host_rd = ($urandom_range(0, 99) < 20);
                host_wdata = 8'($urandom);
                eng_rx_data = 8'($urandom);
                irq_clr_we = ($urandom_range(0, 9) == 0);
                irq_clr_vec = 7'($urandom);
                run_cycle();
            end
        end

        idle(); run_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule